// File: doc/BRIEF.md
# Monochrome Pixel Tripler Packer

This block prepares one-bit-per-pixel glyph bitmaps for a drawing engine that treats a packed three-byte-per-pixel surface as a plain byte surface. Every source pixel bit has to become three identical bits, one for each colour byte of the target pixel. The block takes a byte stream of bitmap rows and returns a stream of 32-bit host data words that the engine can use directly.

A job starts with a one-cycle `start` pulse while the block is idle. The pulse also supplies the glyph width in pixels, the glyph height in rows, and a mode select. In tripling mode each row uses a whole number of input bytes. Each row also produces a whole number of output bytes: any pad bits at the end of a row are dropped on input and zero-filled on output. In pass-through mode the input bytes are packed into words unchanged. This mode serves engines that do the tripling themselves. Both streams use a valid/ready handshake. A one-cycle `done` pulse marks the end of each job.

Top module: `glyph_triple_packer`

## Requirements
- R1: In tripling mode (`cfg_passthru`=0), a job with width w and height h accepts exactly ceil(w/8)*h input bytes, and `in_ready` stays low once they are taken.
- R2: Input pixels are read from input bit 7 toward bit 0, and each pixel bit is written three times in succession. Output bytes are filled from bit 7 toward bit 0.
- R3: At the end of each row, the unused low bits of the current input byte are dropped and the next row begins on a new input byte. The current output byte is closed early with zeros in its unwritten low bits, so each row yields ceil(3w/8) output bytes.
- R4: Output bytes are grouped four to a word, with the first byte in bits 7:0 and the fourth in bits 31:24. A last word with fewer than four bytes is sent with zeros in its unused upper bytes, and no word follows it.
- R5: In pass-through mode (`cfg_passthru`=1), exactly ceil(w/8)*h input bytes are packed unchanged into words with the same byte order and padding as R4.
- R6: A start with zero width or zero height accepts no input, produces no word, and raises `done` in the cycle after the start.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` does not change.
- R8: `in_ready` is low in every cycle in which `out_valid` is high.
- R9: `done` is high for one cycle, in the cycle after the final word of a job is accepted, and at no other time.
- R10: A `start` pulse while a job is running is ignored, and the running job's output is unchanged.
- R11: After reset, `in_ready`, `out_valid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a job when the block is idle |
| cfg_width | input | W_BITS (10) | Glyph width in pixels, sampled at start |
| cfg_height | input | H_BITS (8) | Glyph height in rows, sampled at start |
| cfg_passthru | input | 1 | 1 selects pass-through packing, 0 selects tripling |
| in_data | input | 8 | Bitmap byte |
| in_valid | input | 1 | Input byte is offered |
| in_ready | output | 1 | Input byte is taken at this edge when valid |
| out_data | output | 32 | Packed host data word |
| out_valid | output | 1 | Output word is offered |
| out_ready | input | 1 | Consumer takes the word at this edge |
| done | output | 1 | One-cycle end-of-job pulse |

## Verification
An input byte or output word counts as transferred at the rising edge where both sides of its handshake are high. The bench sets its inputs at the falling edge and samples the handshake signals one nanosecond later, so every transfer is recorded for the edge that makes it. `done` is due one edge after the final word is accepted, or one edge after a zero-size start. It is checked at the next sample point, and any `done` seen at another sample point is a failure. Hold and blocking rules are checked at every sample point, comparing against the previous sample point across the single edge between them. Byte and word counts are checked once `done` arrives.

// File: rtl/gtp_pkg.sv
package gtp_pkg;

    localparam int unsigned BYTE_BITS  = 8;
    localparam int unsigned WORD_BYTES = 4;
    localparam int unsigned WORD_BITS  = BYTE_BITS * WORD_BYTES;
    localparam int unsigned COPIES     = 3;

    typedef logic [BYTE_BITS-1:0] byte_t;

    // One packed byte travelling from an engine to the word packer.
    typedef struct packed {
        logic  last;
        byte_t data;
    } lane_t;

    typedef enum logic {
        JOB_IDLE,
        JOB_RUN
    } job_state_e;

    // Number of whole bytes needed to hold a row of n single-bit pixels.
    function automatic int unsigned row_bytes(input int unsigned n);
        return (n + BYTE_BITS - 1) / BYTE_BITS;
    endfunction

endpackage

// File: rtl/gtp_tripler.sv
module gtp_tripler
    import gtp_pkg::*;
#(
    parameter int unsigned W_BITS = 10,
    parameter int unsigned H_BITS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [W_BITS-1:0] cfg_w,
    input  logic [H_BITS-1:0] cfg_h,
    input  byte_t             in_data,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              hold,
    output lane_t             lane_o,
    output logic              lane_valid,
    input  logic              lane_ready
);

    localparam int unsigned REP_W   = $clog2(COPIES);
    localparam int unsigned IDX_W   = $clog2(BYTE_BITS);
    localparam logic [REP_W-1:0] REP_LAST = REP_W'(COPIES - 1);
    localparam logic [IDX_W-1:0] IDX_TOP  = IDX_W'(BYTE_BITS - 1);

    logic              active;
    logic              src_ok;
    logic              src_done;
    byte_t             src_q;
    logic [IDX_W-1:0]  src_bit;
    logic [REP_W-1:0]  rep;
    logic [W_BITS-1:0] width_q;
    logic [W_BITS-1:0] pix_left;
    logic [H_BITS-1:0] rows_left;
    byte_t             ob_q;
    byte_t             ob_next;
    logic [IDX_W-1:0]  ob_idx;
    logic              ob_full;
    logic              ob_last;

    logic step;
    logic pix_done;
    logic row_end;
    logic close_byte;
    logic take_in;
    logic hand_off;

    assign in_ready   = active && !src_ok && !src_done && !hold;
    assign take_in    = in_valid && in_ready;
    assign step       = active && src_ok && !ob_full;
    assign pix_done   = (rep == REP_LAST);
    assign row_end    = pix_done && (pix_left == W_BITS'(1));
    assign close_byte = (ob_idx == '0) || row_end;
    assign lane_valid = ob_full;
    assign lane_o     = '{last: ob_last, data: ob_q};
    assign hand_off   = lane_valid && lane_ready;

    always_comb begin
        ob_next         = ob_q;
        ob_next[ob_idx] = src_q[src_bit];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active    <= 1'b0;
            src_ok    <= 1'b0;
            src_done  <= 1'b0;
            src_q     <= '0;
            src_bit   <= IDX_TOP;
            rep       <= '0;
            width_q   <= '0;
            pix_left  <= '0;
            rows_left <= '0;
            ob_q      <= '0;
            ob_idx    <= IDX_TOP;
            ob_full   <= 1'b0;
            ob_last   <= 1'b0;
        end else if (load) begin
            active    <= 1'b1;
            src_ok    <= 1'b0;
            src_done  <= 1'b0;
            src_bit   <= IDX_TOP;
            rep       <= '0;
            width_q   <= cfg_w;
            pix_left  <= cfg_w;
            rows_left <= cfg_h;
            ob_q      <= '0;
            ob_idx    <= IDX_TOP;
            ob_full   <= 1'b0;
            ob_last   <= 1'b0;
        end else begin
            if (take_in) begin
                src_q   <= in_data;
                src_ok  <= 1'b1;
                src_bit <= IDX_TOP;
            end
            if (step) begin
                ob_q <= ob_next;
                rep  <= pix_done ? '0 : rep + REP_W'(1);
                if (close_byte) begin
                    ob_idx  <= IDX_TOP;
                    ob_full <= 1'b1;
                end else begin
                    ob_idx <= ob_idx - IDX_W'(1);
                end
                if (pix_done) begin
                    src_bit  <= src_bit - IDX_W'(1);
                    pix_left <= pix_left - W_BITS'(1);
                    if (src_bit == '0 || row_end) begin
                        src_ok <= 1'b0;
                    end
                end
                if (row_end) begin
                    pix_left  <= width_q;
                    rows_left <= rows_left - H_BITS'(1);
                    if (rows_left == H_BITS'(1)) begin
                        src_done <= 1'b1;
                        ob_last  <= 1'b1;
                    end
                end
            end
            if (hand_off) begin
                ob_full <= 1'b0;
                ob_q    <= '0;
                ob_last <= 1'b0;
                if (ob_last) begin
                    active <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/gtp_passthru.sv
module gtp_passthru
    import gtp_pkg::*;
#(
    parameter int unsigned W_BITS = 10,
    parameter int unsigned H_BITS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [W_BITS-1:0] cfg_w,
    input  logic [H_BITS-1:0] cfg_h,
    input  byte_t             in_data,
    input  logic              in_valid,
    output logic              in_ready,
    output lane_t             lane_o,
    output logic              lane_valid,
    input  logic              lane_ready
);

    localparam int unsigned SHIFT = $clog2(BYTE_BITS);
    localparam int unsigned BPR_W = W_BITS - SHIFT + 1;
    localparam int unsigned CNT_W = BPR_W + H_BITS;

    logic              active;
    logic [CNT_W-1:0]  left;
    logic [W_BITS:0]   w_round;
    logic [BPR_W-1:0]  per_row;
    logic [CNT_W-1:0]  total;
    logic              xfer;

    assign w_round = {1'b0, cfg_w} + (W_BITS + 1)'(BYTE_BITS - 1);
    assign per_row = w_round[W_BITS:SHIFT];
    assign total   = CNT_W'(per_row) * CNT_W'(cfg_h);

    assign lane_valid = active && in_valid;
    assign in_ready   = active && lane_ready;
    assign lane_o     = '{last: (left == CNT_W'(1)), data: in_data};
    assign xfer       = lane_valid && lane_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            left   <= '0;
        end else if (load) begin
            active <= 1'b1;
            left   <= total;
        end else if (xfer) begin
            left <= left - CNT_W'(1);
            if (left == CNT_W'(1)) begin
                active <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/gtp_word_pack.sv
module gtp_word_pack
    import gtp_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  lane_t                lane_i,
    input  logic                 lane_valid,
    output logic                 lane_ready,
    output logic [WORD_BITS-1:0] out_data,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic                 out_final
);

    localparam int unsigned IDX_W = $clog2(WORD_BYTES);

    logic [IDX_W-1:0] slot;
    logic             full;
    logic             final_q;
    logic             take_in;
    logic             take_out;
    logic             seal;

    assign lane_ready = !full;
    assign take_in    = lane_valid && lane_ready;
    assign out_valid  = full;
    assign take_out   = full && out_ready;
    assign out_final  = final_q;
    assign seal       = (slot == IDX_W'(WORD_BYTES - 1)) || lane_i.last;

    for (genvar g = 0; g < WORD_BYTES; g++) begin : g_slot
        byte_t slot_q;
        always_ff @(posedge clk) begin
            if (rst || take_out) begin
                slot_q <= '0;
            end else if (take_in && slot == IDX_W'(g)) begin
                slot_q <= lane_i.data;
            end
        end
        assign out_data[g*BYTE_BITS +: BYTE_BITS] = slot_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slot    <= '0;
            full    <= 1'b0;
            final_q <= 1'b0;
        end else if (take_out) begin
            full    <= 1'b0;
            final_q <= 1'b0;
        end else if (take_in) begin
            if (seal) begin
                slot    <= '0;
                full    <= 1'b1;
                final_q <= lane_i.last;
            end else begin
                slot <= slot + IDX_W'(1);
            end
        end
    end

endmodule

// File: rtl/glyph_triple_packer.sv
module glyph_triple_packer
    import gtp_pkg::*;
#(
    parameter int unsigned W_BITS = 10,
    parameter int unsigned H_BITS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [W_BITS-1:0] cfg_width,
    input  logic [H_BITS-1:0] cfg_height,
    input  logic              cfg_passthru,
    input  logic [7:0]        in_data,
    input  logic              in_valid,
    output logic              in_ready,
    output logic [31:0]       out_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              done
);

    job_state_e state;
    logic       pass_q;
    logic       done_q;
    logic       job_busy;
    logic       zero_dim;
    logic       take;
    logic       load_tr;
    logic       load_bp;

    lane_t tr_lane;
    lane_t bp_lane;
    lane_t pk_lane;
    logic  tr_lane_v;
    logic  bp_lane_v;
    logic  pk_lane_v;
    logic  pk_lane_rdy;
    logic  tr_in_rdy;
    logic  bp_in_rdy;
    logic  pk_final;

    assign job_busy = (state == JOB_RUN);
    assign zero_dim = (cfg_width == '0) || (cfg_height == '0);
    assign take     = start && (state == JOB_IDLE);
    assign load_tr  = take && !zero_dim && !cfg_passthru;
    assign load_bp  = take && !zero_dim && cfg_passthru;

    gtp_tripler #(.W_BITS(W_BITS), .H_BITS(H_BITS)) u_tripler (
        .clk        (clk),
        .rst        (rst),
        .load       (load_tr),
        .cfg_w      (cfg_width),
        .cfg_h      (cfg_height),
        .in_data    (in_data),
        .in_valid   (in_valid),
        .in_ready   (tr_in_rdy),
        .hold       (out_valid),
        .lane_o     (tr_lane),
        .lane_valid (tr_lane_v),
        .lane_ready (pk_lane_rdy)
    );

    gtp_passthru #(.W_BITS(W_BITS), .H_BITS(H_BITS)) u_passthru (
        .clk        (clk),
        .rst        (rst),
        .load       (load_bp),
        .cfg_w      (cfg_width),
        .cfg_h      (cfg_height),
        .in_data    (in_data),
        .in_valid   (in_valid),
        .in_ready   (bp_in_rdy),
        .lane_o     (bp_lane),
        .lane_valid (bp_lane_v),
        .lane_ready (pk_lane_rdy)
    );

    assign pk_lane   = pass_q ? bp_lane   : tr_lane;
    assign pk_lane_v = pass_q ? bp_lane_v : tr_lane_v;
    assign in_ready  = pass_q ? bp_in_rdy : tr_in_rdy;

    gtp_word_pack u_pack (
        .clk        (clk),
        .rst        (rst),
        .lane_i     (pk_lane),
        .lane_valid (pk_lane_v),
        .lane_ready (pk_lane_rdy),
        .out_data   (out_data),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .out_final  (pk_final)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= JOB_IDLE;
            pass_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (take) begin
                pass_q <= cfg_passthru;
                if (zero_dim) begin
                    done_q <= 1'b1;
                end else begin
                    state <= JOB_RUN;
                end
            end
            if (job_busy && out_valid && out_ready && pk_final) begin
                state  <= JOB_IDLE;
                done_q <= 1'b1;
            end
        end
    end

    assign done = done_q;

endmodule

// File: rtl/gtp_checker.sv
module gtp_checker (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic        in_ready,
    input logic        out_valid,
    input logic        out_ready,
    input logic [31:0] out_data,
    input logic        done,
    input logic        busy
);

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data)); // R7

    AST_IN_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !in_ready); // R8

    AST_IDLE_NO_INPUT: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !in_ready); // R1

    AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(out_valid && out_ready) || $past(start)); // R9

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy); // R9

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        busy && start && !(out_valid && out_ready) |=> busy); // R10

endmodule

bind glyph_triple_packer gtp_checker u_gtp_checker (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .done      (done),
    .busy      (job_busy)
);

// File: tb/glyph_triple_packer_bench.sv
`timescale 1ns/1ps
module glyph_triple_packer_bench;

    localparam int W_BITS = 10;
    localparam int H_BITS = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic [W_BITS-1:0] cfg_width = '0;
    logic [H_BITS-1:0] cfg_height = '0;
    logic              cfg_passthru = 1'b0;
    logic [7:0]        in_data = '0;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [31:0]       out_data;
    logic              out_valid;
    logic              out_ready = 1'b0;
    logic              done;

    always #10 clk = ~clk;

    glyph_triple_packer #(.W_BITS(W_BITS), .H_BITS(H_BITS)) u_glyph_triple_packer (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .cfg_width    (cfg_width),
        .cfg_height   (cfg_height),
        .cfg_passthru (cfg_passthru),
        .in_data      (in_data),
        .in_valid     (in_valid),
        .in_ready     (in_ready),
        .out_data     (out_data),
        .out_valid    (out_valid),
        .out_ready    (out_ready),
        .done         (done)
    );

    int checks = 0;
    int fails  = 0;
    int seed   = 32'h1234_5677;

    logic [7:0]  src   [256];
    logic [7:0]  obyte [256];
    logic [31:0] expw  [64];
    int n_src;
    int n_ob;
    int n_exp;

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, expv);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    function automatic logic [7:0] next_rand();
        seed = seed * 1103515245 + 12345;
        return seed[23:16];
    endfunction

    task automatic build(input int w, input int h, input bit pass);
        int bpr;
        int rb;
        bpr   = (w + 7) / 8;
        n_src = (w == 0 || h == 0) ? 0 : bpr * h;
        for (int i = 0; i < n_src; i++) src[i] = next_rand();
        for (int i = 0; i < 256; i++) obyte[i] = 8'h00;
        if (n_src == 0) begin
            n_ob = 0;
        end else if (pass) begin
            n_ob = n_src;
            for (int i = 0; i < n_src; i++) obyte[i] = src[i];
        end else begin
            rb   = (3 * w + 7) / 8;
            n_ob = rb * h;
            for (int r = 0; r < h; r++) begin
                for (int q = 0; q < 3 * w; q++) begin
                    int p;
                    p = q / 3;
                    obyte[r * rb + q / 8][7 - (q % 8)] = src[r * bpr + p / 8][7 - (p % 8)];
                end
            end
        end
        n_exp = (n_ob + 3) / 4;
        for (int i = 0; i < n_exp; i++) begin
            expw[i] = '0;
            for (int k = 0; k < 4; k++) begin
                if (4 * i + k < n_ob) expw[i][8*k +: 8] = obyte[4 * i + k];
            end
        end
    endtask

    task automatic run_job(input int w, input int h, input bit pass, input int pat,
                           input bit intrude);
        int  ip;
        int  op;
        int  it;
        bit  exp_done;
        bit  got_done;
        bit  prev_hold;
        bit  hold_bad;
        bit  block_bad;
        logic [31:0] prev_data;
        string wtag;
        build(w, h, pass);
        wtag = pass ? "R5 passthru word" : "R2 R3 R4 tripled word";
        ip = 0; op = 0; it = 0;
        exp_done = 0; got_done = 0; prev_hold = 0; hold_bad = 0; block_bad = 0;
        prev_data = '0;
        while (!got_done && it < 6000) begin
            @(negedge clk);
            if (done) begin
                if (exp_done) check(1'b1, "R9 done", 32'(done), 32'd1);
                else check(1'b0, "R9 early done", 32'(done), 32'd0);
                got_done = 1;
            end else if (exp_done) begin
                check(1'b0, "R9 done missing", 32'(done), 32'd1);
                break;
            end
            exp_done = 0;
            if (got_done) break;
            start = (it == 0) || (intrude && it == 6);
            if (it == 0) begin
                cfg_width = W_BITS'(w); cfg_height = H_BITS'(h); cfg_passthru = pass;
            end else if (it == 6) begin
                cfg_width = W_BITS'(5); cfg_height = '0; cfg_passthru = ~pass;
            end
            in_valid  = !(pat != 0 && (it % (pat + 2)) == 1);
            in_data   = (ip < n_src) ? src[ip] : 8'hC3;
            out_ready = (pat == 0) ? 1'b1 : ((it % (pat + 3)) != 0);
            #1;
            if (prev_hold && !(out_valid && out_data == prev_data)) hold_bad = 1;
            if (out_valid && in_ready) block_bad = 1;
            prev_hold = out_valid && !out_ready;
            prev_data = out_data;
            if (in_valid && in_ready) ip++;
            if (out_valid) begin
                if (op >= n_exp) begin
                    check(1'b0, "R4 extra word", out_data, 32'h0);
                end else if (out_ready) begin
                    check(out_data == expw[op], wtag, out_data, expw[op]);
                    op++;
                    if (op == n_exp) exp_done = 1;
                end
            end
            if (it == 0 && n_exp == 0) exp_done = 1;
            it++;
        end
        start = 0;
        in_valid = 0;
        if (!got_done) check(1'b0, "R9 no done", 32'(it), 32'd0);
        if (n_src == 0) begin
            check(ip == 0, "R6 zero-size input bytes", 32'(ip), 32'd0);
            check(op == 0, "R6 zero-size words", 32'(op), 32'd0);
        end else if (pass) begin
            check(ip == n_src, "R5 input byte count", 32'(ip), 32'(n_src));
        end else begin
            check(ip == n_src, "R1 input byte count", 32'(ip), 32'(n_src));
        end
        check(op == n_exp, "R4 word count", 32'(op), 32'(n_exp));
        check(!hold_bad, "R7 output held", 32'(hold_bad), 32'd0);
        check(!block_bad, "R8 input blocked", 32'(block_bad), 32'd0);
        if (intrude) check(got_done && op == n_exp, "R10 start ignored", 32'(op), 32'(n_exp));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        check(1'b0, "R9 watchdog expired", 32'd0, 32'd1);
        summary();
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check(!in_ready, "R11 reset in_ready", 32'(in_ready), 32'd0);
        check(!out_valid, "R11 reset out_valid", 32'(out_valid), 32'd0);
        check(!done, "R11 reset done", 32'(done), 32'd0);

        run_job(0, 3, 1'b0, 1, 1'b0);
        run_job(7, 0, 1'b1, 2, 1'b0);

        for (int w = 1; w <= 20; w++) begin
            for (int h = 1; h <= 3; h++) begin
                run_job(w, h, 1'b0, (w + h) % 4, (w >= 16) && (h == 2));
            end
        end
        run_job(33, 2, 1'b0, 3, 1'b1);
        run_job(64, 1, 1'b0, 0, 1'b0);

        for (int w = 1; w <= 24; w++) begin
            for (int h = 1; h <= 3; h++) begin
                run_job(w, h, 1'b1, (w + 2 * h) % 4, (w == 24) && (h == 3));
            end
        end
        run_job(0, 0, 1'b1, 0, 1'b0);

        summary();
        $finish;
    end

endmodule